// File: doc/BRIEF.md
# SPI Master with Register Interface

This block is a byte-wide SPI master that a processor controls through three small registers: control, status and data. Software sets the clock divider, the clock polarity and phase mode, the bit order and an enable bit in the control register. It then writes a byte to the data register. The master shifts that byte out on MOSI and, in the same 16 SCK half-periods, shifts a byte in from MISO. The received byte is placed in a small receive queue, and software reads it back through the same data register.

The transmit side has a holding register in front of the shift register. Software can therefore queue a second byte while the first is still on the wire, and the two bytes go out back to back. The block drives no chip select, so software drives slave selects from general-purpose outputs. When nothing is queued, SCK rests at the idle level of the selected mode and MOSI keeps the last bit it sent.

Register addresses: 0 is control, 1 is status, 2 is data. Address 3 reads as zero and ignores writes.

Top module: `spi_master_regs`

## Requirements
- R1: After reset, control and status read as 0x00, SCK is low and MOSI is low.
- R2: Control bits 6:4 are the divider code, bit 3 selects LSB first, bits 2:1 select the mode and bit 0 is enable. A control read returns the bits last written, and bit 7 always reads 0.
- R3: With divider code c, one SCK period lasts 2^(c+1) system clock cycles for c = 0 to 5. Codes 6 and 7 give 64 cycles.
- R4: Mode bit 2 sets the SCK idle level: 0 idles low (modes 0 and 1) and 1 idles high (modes 2 and 3). Mode bit 1 picks the sampling edge: 0 samples MISO on the leading edge (modes 0 and 2) and 1 samples on the trailing edge (modes 1 and 3). The slave sees MOSI stable on that same edge.
- R5: With control bit 3 set, bit 0 of the byte goes out first and the first bit received lands in bit 0. With bit 3 clear, bit 7 goes first in both directions.
- R6: A data write starts a transfer only while enable is set. While enable is clear, the byte waits in the holding register (status bit 1 set) and SCK does not toggle. The transfer starts once enable is set. Status bit 0 is 1 while a byte is shifting.
- R7: A byte written while a transfer runs waits in the holding register (status bit 1 = 1) and starts right after the current byte. A data write is ignored while the holding register is occupied and no transfer starts in that cycle.
- R8: Status bit 2 is 1 while the receive queue holds data. A data read returns the oldest byte and removes it. A data read on an empty queue changes nothing.
- R9: A byte that completes while the receive queue (default depth 2) is full, with no read in that cycle, is discarded, and the queued bytes stay intact.
- R10: While idle, MOSI holds the last bit sent and SCK holds the idle level of the mode.
- R11: A data read and a transfer completion in the same cycle both take effect. The read returns the older byte and the new byte stays queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read pops the queue) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |

## Verification
Two actions can land on the receive queue in the same clock edge: the shifter pushes a finished byte, and software pops through a data read. The bench preloads one byte and starts a second transfer. It then issues the data read at a sweep of offsets around the cycle where that transfer ends, so one offset hits the exact cycle. At every offset the read must return the preloaded byte, and the new byte must still be readable afterwards with the queue then empty. A similar collision, a data write in the cycle the holding register empties into the shifter, is provoked by three writes on consecutive cycles. Exactly the first two bytes must reach the slave.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
    localparam int BYTE_W      = 8;
    localparam int DIV_EXP_MAX = 5;   // largest half-period exponent (divide by 64)

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // control register, bit 6 down to bit 0
    typedef struct packed {
        logic [2:0] div_code;
        logic       lsb_first;
        logic [1:0] mode;      // mode[1] idle level, mode[0] trailing-edge sampling
        logic       enable;
    } ctrl_t;

    function automatic logic [2:0] half_exp(input logic [2:0] code);
        return (code > 3'(DIV_EXP_MAX)) ? 3'(DIV_EXP_MAX) : code;
    endfunction
endpackage

// File: rtl/spim_clkgen.sv
`timescale 1ns/1ps
module spim_clkgen
    import spim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] code,
    output logic       tick
);
    localparam int CW = (DIV_EXP_MAX < 1) ? 1 : DIV_EXP_MAX;

    logic [CW-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        limit = CW'((1 << half_exp(code)) - 1);
        tick  = run && (cnt_q == limit);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // half period longer than one cycle: edges never come back to back (R3)
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && limit != '0) |=> !tick);
endmodule

// File: rtl/spim_shift.sv
`timescale 1ns/1ps
module spim_shift
    import spim_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] start_data,
    input  logic [1:0]   cfg_mode,
    input  logic         cfg_lsb,
    input  logic [2:0]   cfg_div,
    input  logic         live_cpol,
    input  logic         tick,
    input  logic         miso,
    output logic         busy,
    output logic         sck,
    output logic         mosi,
    output logic         done,
    output logic [W-1:0] rx_data,
    output logic [2:0]   div_code
);
    localparam int EW = $clog2(2 * W);
    localparam logic [EW-1:0] LAST = EW'(2 * W - 1);

    typedef struct packed {
        logic          busy;
        logic [EW-1:0] edg;
        logic          phase;
        logic          cpol;
        logic          cpha;
        logic          lsb;
        logic [2:0]    div;
        logic [W-1:0]  tx;
        logic [W-1:0]  rx;
        logic          mosi;
        logic          sck;
    } sh_t;

    sh_t  d, q;
    logic lead, smp, drv;

    function automatic logic out_bit(input logic [W-1:0] sr, input logic lsb);
        return lsb ? sr[0] : sr[W-1];
    endfunction

    function automatic logic [W-1:0] shift_out(input logic [W-1:0] sr, input logic lsb);
        return lsb ? (sr >> 1) : (sr << 1);
    endfunction

    function automatic logic [W-1:0] shift_in(input logic [W-1:0] sr, input logic lsb,
                                              input logic b);
        return lsb ? {b, sr[W-1:1]} : {sr[W-2:0], b};
    endfunction

    always_comb begin
        d    = q;
        done = 1'b0;
        lead = 1'b0;
        smp  = 1'b0;
        drv  = 1'b0;
        if (q.busy && tick) begin
            lead    = ~q.edg[0];
            smp     = lead ^ q.cpha;
            drv     = ~smp & ~(~q.cpha & (q.edg == LAST));
            d.phase = ~q.phase;
            d.edg   = q.edg + 1'b1;
            if (smp) d.rx = shift_in(q.rx, q.lsb, miso);
            if (drv) begin
                d.mosi = out_bit(q.tx, q.lsb);
                d.tx   = shift_out(q.tx, q.lsb);
            end
            if (q.edg == LAST) begin
                d.busy = 1'b0;
                done   = 1'b1;
            end
        end
        rx_data = d.rx;
        if (start) begin
            d.busy  = 1'b1;
            d.edg   = '0;
            d.phase = 1'b0;
            d.cpol  = cfg_mode[1];
            d.cpha  = cfg_mode[0];
            d.lsb   = cfg_lsb;
            d.div   = cfg_div;
            d.rx    = '0;
            d.tx    = start_data;
            if (!cfg_mode[0]) begin
                d.mosi = out_bit(start_data, cfg_lsb);
                d.tx   = shift_out(start_data, cfg_lsb);
            end
        end
        d.sck = d.busy ? (d.cpol ^ d.phase) : live_cpol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign sck      = q.sck;
    assign mosi     = q.mosi;
    assign div_code = q.div;

    // idle with nothing starting: MOSI keeps its level (R10)
    p_mosi_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && !start) |=> $stable(q.mosi));

    // a transfer always ends with SCK back at its idle phase (R4)
    p_end_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (q.phase == 1'b0));
endmodule

// File: rtl/spim_rxfifo.sv
`timescale 1ns/1ps
module spim_rxfifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] rp;
        logic [PW-1:0] wp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t        d, q;
    logic [W-1:0] mem [DEPTH];
    logic         accept, take;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d      = q;
        take   = pop && (q.cnt != '0);
        accept = push && ((q.cnt != CW'(DEPTH)) || take);
        if (take)   d.rp = nxt(q.rp);
        if (accept) d.wp = nxt(q.wp);
        d.cnt = q.cnt + CW'(accept) - CW'(take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem[q.wp] <= din;
    end

    assign dout  = mem[q.rp];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));

    p_drop_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(q.wp) && $stable(q.rp)));

    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/spi_master_regs.sv
`timescale 1ns/1ps
module spi_master_regs
    import spim_pkg::*;
#(
    parameter int RX_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    typedef struct packed {
        ctrl_t      ctrl;
        logic [7:0] hold;
        logic       hold_v;
    } top_t;

    top_t       d, q;
    reg_sel_e   sel;
    logic       start, busy, done, pop, rx_empty, rx_full, tick;
    logic [7:0] rx_byte, rx_head;
    logic [2:0] div_code;
    logic       unused_wdata_msb;

    assign unused_wdata_msb = reg_wdata[7];

    always_comb begin
        sel   = reg_sel_e'(reg_addr);
        d     = q;
        start = q.ctrl.enable && q.hold_v && (!busy || done);
        pop   = reg_rd && (sel == SEL_DATA) && !rx_empty;
        if (start) d.hold_v = 1'b0;
        if (reg_wr && (sel == SEL_DATA) && (!q.hold_v || start)) begin
            d.hold   = reg_wdata;
            d.hold_v = 1'b1;
        end
        if (reg_wr && (sel == SEL_CTRL)) d.ctrl = ctrl_t'(reg_wdata[6:0]);
        case (sel)
            SEL_CTRL: reg_rdata = {1'b0, q.ctrl};
            SEL_STAT: reg_rdata = {5'b0, !rx_empty, q.hold_v, busy};
            SEL_DATA: reg_rdata = rx_head;
            default:  reg_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    spim_clkgen u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .code  (div_code),
        .tick  (tick)
    );

    spim_shift #(.W(BYTE_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_data (q.hold),
        .cfg_mode   (q.ctrl.mode),
        .cfg_lsb    (q.ctrl.lsb_first),
        .cfg_div    (q.ctrl.div_code),
        .live_cpol  (q.ctrl.mode[1]),
        .tick       (tick),
        .miso       (spi_miso),
        .busy       (busy),
        .sck        (spi_sck),
        .mosi       (spi_mosi),
        .done       (done),
        .rx_data    (rx_byte),
        .div_code   (div_code)
    );

    spim_rxfifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (done),
        .din   (rx_byte),
        .pop   (pop),
        .dout  (rx_head),
        .empty (rx_empty),
        .full  (rx_full)
    );

    p_idle_sck_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(q.ctrl.mode)) |-> (spi_sck == q.ctrl.mode[1]));

    p_no_start_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ctrl.enable && !busy) |=> !busy);

    p_queue_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hold_v && busy && !done) |=> q.hold_v);

    p_pop_with_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && done && pop) |=> !rx_empty);
endmodule

// File: tb/sim_spi_master_regs.sv
`timescale 1ns/1ps
module sim_spi_master_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       sck, mosi, miso;

    int vecs = 0, errs = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spi_master_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
        .reg_wdata(wdata), .reg_rdata(rdata), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso)
    );

    // slave model
    bit         s_on = 0, s_cpol = 0, s_cpha = 0, s_lsb = 0;
    int         s_n = 0, s_cnt = 0;
    logic [7:0] s_out [8];
    logic [7:0] s_got [8];
    logic [7:0] s_rx = 8'h00;

    always_comb begin
        int i;
        i = s_cpha ? ((s_n == 0) ? 0 : (s_n - 1) / 2) : s_n / 2;
        if (i > 7) i = 7;
        miso = s_lsb ? s_out[s_cnt % 8][i] : s_out[s_cnt % 8][7 - i];
    end

    always @(posedge sck or negedge sck) begin
        if (s_on) begin
            bit lead;
            lead = (sck != s_cpol);
            if (lead ^ s_cpha) s_rx = s_lsb ? {mosi, s_rx[7:1]} : {s_rx[6:0], mosi};
            s_n++;
            if (s_n == 16) begin
                s_got[s_cnt % 8] = s_rx;
                s_cnt++;
                s_n = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); addr = a; wdata = v; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd = 1'b1; #1 v = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] st;
        do reg_rd(2'd1, st); while (st[1:0] != 2'b00);
    endtask

    task automatic drain();
        logic [7:0] st, v;
        reg_rd(2'd1, st);
        while (st[2]) begin
            reg_rd(2'd2, v);
            reg_rd(2'd1, st);
        end
    endtask

    task automatic slave_arm(input logic [1:0] mode, input bit lsb);
        s_on = 0;
        repeat (2) @(negedge clk);
        s_cpol = mode[1]; s_cpha = mode[0]; s_lsb = lsb;
        s_n = 0; s_cnt = 0; s_rx = 8'h00;
        s_on = 1;
    endtask

    function automatic logic [7:0] ctl(input int code, input bit lsb, input logic [1:0] mode,
                                       input bit en);
        return {1'b0, 3'(code), lsb, mode, en};
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        check(sck == 1'b0 && mosi == 1'b0, "R1 pins", {sck, mosi}, 0);
        reg_rd(2'd0, v); check(v == 8'h00, "R1 control", v, 0);
        reg_rd(2'd1, v); check(v == 8'h00, "R1 status", v, 0);
    endtask

    task automatic t_ctrl();
        logic [7:0] v;
        reg_wr(2'd0, 8'hFF); reg_rd(2'd0, v); check(v == 8'h7F, "R2 readback", v, 8'h7F);
        reg_wr(2'd0, 8'h35); reg_rd(2'd0, v); check(v == 8'h35, "R2 readback", v, 8'h35);
        reg_wr(2'd0, 8'h00);
    endtask

    task automatic t_xfer(input logic [1:0] mode, input bit lsb, input int code,
                          input logic [7:0] tx, input logic [7:0] sv);
        logic [7:0] v;
        reg_wr(2'd0, ctl(code, lsb, mode, 1'b1));
        slave_arm(mode, lsb);
        s_out[0] = sv;
        reg_wr(2'd2, tx);
        wait_idle();
        reg_rd(2'd1, v);  check(v[2] == 1'b1, "R8 data available", v, 8'h04);
        reg_rd(2'd2, v);  check(v == sv, lsb ? "R5 received byte" : "R4 received byte", v, sv);
        check(s_got[0] == tx, lsb ? "R5 slave saw byte" : "R4 slave saw byte", s_got[0], tx);
        check(sck == mode[1], "R4 idle level", sck, mode[1]);
        check(mosi == (lsb ? tx[7] : tx[0]), "R10 MOSI holds last bit", mosi, lsb ? tx[7] : tx[0]);
        reg_rd(2'd1, v);  check(v == 8'h00, "R8 status clears after read", v, 0);
    endtask

    task automatic t_period(input int code, input int exp);
        realtime t0, t1;
        int cyc;
        reg_wr(2'd0, ctl(code, 1'b0, 2'b00, 1'b1));
        slave_arm(2'b00, 1'b0);
        s_out[0] = 8'h00;
        reg_wr(2'd2, 8'hC3);
        @(posedge sck); t0 = $realtime;
        @(posedge sck); t1 = $realtime;
        cyc = int'((t1 - t0) / 5.0);
        check(cyc == exp, "R3 SCK period", cyc, exp);
        wait_idle();
        drain();
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        reg_wr(2'd0, ctl(0, 1'b0, 2'b00, 1'b0));
        slave_arm(2'b00, 1'b0);
        s_out[0] = 8'h99;
        reg_wr(2'd2, 8'h5A);
        repeat (40) @(negedge clk);
        check(s_n == 0 && s_cnt == 0, "R6 no SCK while disabled", s_n, 0);
        reg_rd(2'd1, v); check(v == 8'h02, "R6 byte waits", v, 8'h02);
        reg_wr(2'd0, ctl(0, 1'b0, 2'b00, 1'b1));
        wait_idle();
        check(s_cnt == 1 && s_got[0] == 8'h5A, "R6 starts on enable", s_got[0], 8'h5A);
        reg_rd(2'd2, v); check(v == 8'h99, "R6 received", v, 8'h99);
    endtask

    task automatic t_double();
        logic [7:0] v;
        reg_wr(2'd0, ctl(2, 1'b0, 2'b01, 1'b1));
        slave_arm(2'b01, 1'b0);
        s_out[0] = 8'h11; s_out[1] = 8'h22;
        reg_wr(2'd2, 8'hA5);
        reg_wr(2'd2, 8'h3C);
        reg_rd(2'd1, v); check(v[1:0] == 2'b11, "R7 second byte queued", v, 8'h03);
        wait_idle();
        check(s_cnt == 2, "R7 two bytes sent", s_cnt, 2);
        check(s_got[0] == 8'hA5 && s_got[1] == 8'h3C, "R7 order on wire",
              {s_got[0], s_got[1]}, 16'hA53C);
        reg_rd(2'd2, v); check(v == 8'h11, "R8 oldest first", v, 8'h11);
        reg_rd(2'd2, v); check(v == 8'h22, "R8 second byte", v, 8'h22);
        reg_rd(2'd1, v); check(v == 8'h00, "R8 queue empty", v, 0);
    endtask

    task automatic t_drop();
        logic [7:0] v;
        reg_wr(2'd0, ctl(0, 1'b0, 2'b00, 1'b1));
        slave_arm(2'b00, 1'b0);
        s_out[0] = 8'h01; s_out[1] = 8'h02;
        @(negedge clk); addr = 2'd2; wr = 1'b1; wdata = 8'h81;
        @(negedge clk); wdata = 8'h42;
        @(negedge clk); wdata = 8'h24;
        @(negedge clk); wr = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        check(s_cnt == 2, "R7 third write ignored", s_cnt, 2);
        check(s_got[0] == 8'h81 && s_got[1] == 8'h42, "R7 accepted bytes",
              {s_got[0], s_got[1]}, 16'h8142);
        drain();
    endtask

    task automatic t_overflow();
        logic [7:0] v;
        reg_wr(2'd0, ctl(0, 1'b0, 2'b00, 1'b1));
        slave_arm(2'b00, 1'b0);
        s_out[0] = 8'hA1; s_out[1] = 8'hA2; s_out[2] = 8'hA3;
        reg_wr(2'd2, 8'h10); wait_idle();
        reg_wr(2'd2, 8'h20); wait_idle();
        reg_wr(2'd2, 8'h30); wait_idle();
        check(s_cnt == 3, "R9 three transfers", s_cnt, 3);
        reg_rd(2'd2, v); check(v == 8'hA1, "R9 first kept", v, 8'hA1);
        reg_rd(2'd2, v); check(v == 8'hA2, "R9 second kept", v, 8'hA2);
        reg_rd(2'd1, v); check(v == 8'h00, "R9 third dropped", v, 0);
    endtask

    task automatic t_empty_read();
        logic [7:0] v;
        reg_rd(2'd2, v);
        reg_rd(2'd1, v); check(v == 8'h00, "R8 empty read no effect", v, 0);
        slave_arm(2'b00, 1'b0);
        s_out[0] = 8'h6E;
        reg_wr(2'd2, 8'h01); wait_idle();
        reg_rd(2'd2, v); check(v == 8'h6E, "R8 after empty read", v, 8'h6E);
        reg_rd(2'd1, v); check(v == 8'h00, "R8 one entry only", v, 0);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        reg_wr(2'd0, ctl(0, 1'b0, 2'b00, 1'b1));
        for (int o = 12; o <= 20; o++) begin
            slave_arm(2'b00, 1'b0);
            s_out[0] = 8'(8'h40 + o); s_out[1] = 8'(8'hC0 + o);
            reg_wr(2'd2, 8'h77); wait_idle();
            reg_wr(2'd2, 8'h88);
            repeat (o) @(negedge clk);
            reg_rd(2'd2, v); check(v == 8'(8'h40 + o), "R11 read returns older", v, 8'h40 + o);
            wait_idle();
            reg_rd(2'd1, v); check(v == 8'h04, "R11 new byte kept", v, 8'h04);
            reg_rd(2'd2, v); check(v == 8'(8'hC0 + o), "R11 new byte value", v, 8'hC0 + o);
            reg_rd(2'd1, v); check(v == 8'h00, "R11 queue then empty", v, 0);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vecs++; errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin s_out[i] = 8'h00; s_got[i] = 8'h00; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_xfer(2'b00, 1'b0, 0, 8'hB4, 8'h5D);
        t_xfer(2'b01, 1'b0, 1, 8'h96, 8'hE1);
        t_xfer(2'b10, 1'b1, 0, 8'h2B, 8'hC8);
        t_xfer(2'b11, 1'b1, 2, 8'hD1, 8'h4F);
        t_xfer(2'b10, 1'b0, 0, 8'h01, 8'h80);
        t_period(0, 2);
        t_period(2, 8);
        t_period(5, 64);
        t_period(7, 64);
        t_disabled();
        t_double();
        t_drop();
        t_overflow();
        t_empty_read();
        t_same_cycle();
        summary();
    end
endmodule